// File: doc/BRIEF.md
# ATA Sector Read Sequencer

This block reads single 512-byte sectors from a CompactFlash card that runs in true-IDE PIO mode with 28-bit LBA addressing. It never touches the IDE pins directly. Every register access goes to a separate register-access engine through a one-cycle request and a done pulse. The host-side front end loads a sector address and then asks for data words one at a time. Each finished request is signalled by a one-cycle `host_done_o` pulse.

When a request arrives and no sector is buffered in the card, the block polls the status register. If the card still holds words of an earlier sector, the block drains them with dummy reads. Once the card allows commands, the block writes the task-file registers and the read command. It then polls until the card raises a data request, and after that it returns the 256 words of the sector without reading status again. If the card reports an error, the block raises a sticky error output, runs a timed soft reset and retries.

Top module: `ata_sector_reader`

## Requirements
- R1: Register selects on `acc_sel_o` are 8 = data, 9 = feature, 10 = sector count, 11/12/13 = LBA bits 7:0 / 15:8 / 23:16, 14 = drive/head, 15 = command (write) or status (read), 6 = device control. A new sector read writes, in this order: 9←0x00, 10←0x01, 11, 12, 13 with the LBA bytes, 14 with the drive/head byte, and 15←0x20.
- R2: The drive/head byte is 0xE0 ORed with LBA bits 27:24.
- R3: The status byte is `acc_rdata_i[7:0]`. Data is ready when (status & 0xC9) == 0x48.
- R4: Commands are allowed when (status & 0xC1) == 0x40. When both tests match, the data-ready meaning takes priority.
- R5: After the read command, status is polled until data is ready. Then each word request costs exactly one data-register read and returns it on `host_word_o`. The 256 words of a sector come back in order, with no status read between them.
- R6: After the 256th word of a sector, the next word request polls status again and issues a fresh read command.
- R7: When a new sector is needed and status shows data ready, dummy data reads are issued until data ready clears. None of these reads is reported to the host. The new command follows once commands are allowed.
- R8: A status read with bit 0 set raises `err_o`. The block then writes 0x04 to device control, waits `RST_WAIT` cycles, and writes 0x00 there. `err_o` falls when that last write completes, and the pending word request is retried.
- R9: `host_load_i` in the idle state latches `host_lba_i`, drops any buffered sector, and pulses `host_done_o` in the next cycle. The next word request then starts a new read at the new address.
- R10: `acc_req_o` is a one-cycle pulse. No new request is raised until `acc_done_i` answers the previous one.
- R11: After reset, `acc_req_o`, `host_done_o` and `err_o` are low.
- R12: A status with neither meaning and no error bit set (for example, BSY set) leads only to another status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_load_i | input | 1 | Load a new sector address |
| host_lba_i | input | 28 | Sector address |
| host_rd_i | input | 1 | Request the next data word |
| host_done_o | output | 1 | One-cycle pulse when a load or word request completes |
| host_word_o | output | 16 | Last word read |
| err_o | output | 1 | Card error seen; held until the soft reset completes |
| acc_req_o | output | 1 | Register access request pulse |
| acc_we_o | output | 1 | Access is a write |
| acc_sel_o | output | 4 | Register select |
| acc_wdata_o | output | 8 | Write data |
| acc_done_i | input | 1 | Access complete |
| acc_rdata_i | input | 16 | Read data of the completed access |

## Verification
A wrong word count shows up at the very next word request. If the count is short, a status read appears where a data read belonged. If it is long, an extra data read is returned where a status poll and a new command should have come, and that bad word reaches `host_word_o`. A stuck or wrongly cleared buffered-sector flag shows up on the first request after an address load or a drain, as a missing or extra command sequence. A mis-decoded status byte shows up on the very next access after the status read, because that access has the wrong select or write data. Error handling shows up on `err_o` and in the gap between the two device-control writes.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam int WORD_W = 16;
  localparam int LBA_W  = 28;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_WORD, S_POLL_PRE, S_DRAIN, S_ISSUE,
    S_POLL_POST, S_SRST_ON, S_SRST_WAIT, S_SRST_OFF
  } seq_state_e;

  localparam logic [3:0] SEL_DATA   = 4'h8;
  localparam logic [3:0] SEL_FEAT   = 4'h9;
  localparam logic [3:0] SEL_COUNT  = 4'hA;
  localparam logic [3:0] SEL_LBA0   = 4'hB;
  localparam logic [3:0] SEL_LBA1   = 4'hC;
  localparam logic [3:0] SEL_LBA2   = 4'hD;
  localparam logic [3:0] SEL_HEAD   = 4'hE;
  localparam logic [3:0] SEL_CMD    = 4'hF;
  localparam logic [3:0] SEL_DEVCTL = 4'h6;

  localparam logic [7:0] CMD_READ   = 8'h20;
  localparam logic [7:0] SRST_SET   = 8'h04;
  localparam logic [7:0] HEAD_BASE  = 8'hE0;
  localparam logic [7:0] MASK_DATA  = 8'hC9;
  localparam logic [7:0] MATCH_DATA = 8'h48;
  localparam logic [7:0] MASK_CMD   = 8'hC1;
  localparam logic [7:0] MATCH_CMD  = 8'h40;

  localparam logic [2:0] ISSUE_LAST = 3'd6;
endpackage

// File: rtl/ata_status_decode.sv
module ata_status_decode
  import ata_seq_pkg::*;
(
  input  logic [7:0] status_i,
  output logic       data_ok_o,
  output logic       cmd_ok_o,
  output logic       err_o
);
  assign err_o     = status_i[0];
  assign data_ok_o = (status_i & MASK_DATA) == MATCH_DATA;
  // data request wins when both patterns match
  assign cmd_ok_o  = !data_ok_o && ((status_i & MASK_CMD) == MATCH_CMD);
endmodule

// File: rtl/ata_word_counter.sv
module ata_word_counter #(
  parameter int WORDS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] TOP = CW'(WORDS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= TOP;
    else if (load_i) cnt_q <= TOP;
    else if (step_i) cnt_q <= (cnt_q == '0) ? TOP : cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/ata_delay_timer.sv
module ata_delay_timer #(
  parameter int CYCLES = 6120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int TW = $clog2(CYCLES + 1);
  localparam logic [TW-1:0] LOADV = TW'(CYCLES - 1);

  logic [TW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= LOADV;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/ata_sector_reader.sv
module ata_sector_reader
  import ata_seq_pkg::*;
#(
  parameter int WORDS_PER_SECTOR = 256,
  parameter int RST_WAIT         = 6120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_load_i,
  input  logic [LBA_W-1:0]  host_lba_i,
  input  logic              host_rd_i,
  output logic              host_done_o,
  output logic [WORD_W-1:0] host_word_o,
  output logic              err_o,
  output logic              acc_req_o,
  output logic              acc_we_o,
  output logic [3:0]        acc_sel_o,
  output logic [7:0]        acc_wdata_o,
  input  logic              acc_done_i,
  input  logic [WORD_W-1:0] acc_rdata_i
);
  seq_state_e       state_q;
  logic             pend_q;
  logic             avail_q;
  logic             err_q;
  logic [2:0]       step_q;
  logic [LBA_W-1:0] lba_q;

  logic is_access, acc_fin;
  logic st_data, st_cmd, st_err;
  logic last_word, ctr_load, ctr_step;
  logic tmr_start, tmr_done;

  assign is_access = (state_q != S_IDLE) && (state_q != S_SRST_WAIT);
  assign acc_fin   = is_access && pend_q && acc_done_i;
  assign acc_req_o = is_access && !pend_q;
  assign err_o     = err_q;

  ata_status_decode u_dec (
    .status_i (acc_rdata_i[7:0]),
    .data_ok_o(st_data),
    .cmd_ok_o (st_cmd),
    .err_o    (st_err)
  );

  assign ctr_load  = acc_fin && (state_q == S_POLL_POST) && !st_err && st_data;
  assign ctr_step  = acc_fin && (state_q == S_RD_WORD);
  assign tmr_start = acc_fin && (state_q == S_SRST_ON);

  ata_word_counter #(.WORDS(WORDS_PER_SECTOR)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ctr_load),
    .step_i(ctr_step),
    .last_o(last_word)
  );

  ata_delay_timer #(.CYCLES(RST_WAIT)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .done_o (tmr_done)
  );

  always_comb begin
    acc_we_o    = 1'b0;
    acc_sel_o   = SEL_DATA;
    acc_wdata_o = '0;
    unique case (state_q)
      S_POLL_PRE, S_POLL_POST: acc_sel_o = SEL_CMD;
      S_SRST_ON: begin
        acc_we_o    = 1'b1;
        acc_sel_o   = SEL_DEVCTL;
        acc_wdata_o = SRST_SET;
      end
      S_SRST_OFF: begin
        acc_we_o  = 1'b1;
        acc_sel_o = SEL_DEVCTL;
      end
      S_ISSUE: begin
        acc_we_o = 1'b1;
        unique case (step_q)
          3'd0: acc_sel_o = SEL_FEAT;
          3'd1: begin acc_sel_o = SEL_COUNT; acc_wdata_o = 8'h01;        end
          3'd2: begin acc_sel_o = SEL_LBA0;  acc_wdata_o = lba_q[7:0];   end
          3'd3: begin acc_sel_o = SEL_LBA1;  acc_wdata_o = lba_q[15:8];  end
          3'd4: begin acc_sel_o = SEL_LBA2;  acc_wdata_o = lba_q[23:16]; end
          3'd5: begin
            acc_sel_o   = SEL_HEAD;
            acc_wdata_o = HEAD_BASE | {4'h0, lba_q[27:24]};
          end
          default: begin acc_sel_o = SEL_CMD; acc_wdata_o = CMD_READ; end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      pend_q      <= 1'b0;
      avail_q     <= 1'b0;
      err_q       <= 1'b0;
      step_q      <= '0;
      lba_q       <= '0;
      host_done_o <= 1'b0;
      host_word_o <= '0;
    end else begin
      host_done_o <= 1'b0;
      if (acc_req_o) pend_q <= 1'b1;
      if (acc_fin) begin
        pend_q <= 1'b0;
        unique case (state_q)
          S_RD_WORD: begin
            host_word_o <= acc_rdata_i;
            host_done_o <= 1'b1;
            if (last_word) avail_q <= 1'b0;
            state_q <= S_IDLE;
          end
          S_POLL_PRE: begin
            if (st_err) begin
              err_q   <= 1'b1;
              state_q <= S_SRST_ON;
            end else if (st_data) state_q <= S_DRAIN;
            else if (st_cmd) begin
              step_q  <= '0;
              state_q <= S_ISSUE;
            end
          end
          S_DRAIN: state_q <= S_POLL_PRE;
          S_ISSUE: begin
            if (step_q == ISSUE_LAST) state_q <= S_POLL_POST;
            else step_q <= step_q + 1'b1;
          end
          S_POLL_POST: begin
            if (st_err) begin
              err_q   <= 1'b1;
              state_q <= S_SRST_ON;
            end else if (st_data) begin
              avail_q <= 1'b1;
              state_q <= S_RD_WORD;
            end
          end
          S_SRST_ON: state_q <= S_SRST_WAIT;
          S_SRST_OFF: begin
            err_q   <= 1'b0;
            avail_q <= 1'b0;
            state_q <= S_POLL_PRE;
          end
          default: ;
        endcase
      end
      if (state_q == S_SRST_WAIT && tmr_done) state_q <= S_SRST_OFF;
      if (state_q == S_IDLE) begin
        if (host_load_i) begin
          lba_q       <= host_lba_i;
          avail_q     <= 1'b0;
          host_done_o <= 1'b1;
        end else if (host_rd_i) begin
          state_q <= avail_q ? S_RD_WORD : S_POLL_PRE;
        end
      end
    end
  end
endmodule

// File: rtl/ata_sector_reader_chk.sv
module ata_sector_reader_chk
  import ata_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_load_i,
  input logic       host_done_o,
  input logic       err_o,
  input logic       acc_req_o,
  input logic       acc_we_o,
  input logic [3:0] acc_sel_o,
  input logic [7:0] acc_wdata_o,
  input logic       acc_done_i
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= 1'b0;
    else if (acc_req_o) outst_q <= 1'b1;
    else if (acc_done_i) outst_q <= 1'b0;
  end

  a_r10_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o |-> !outst_q);

  a_r10_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o |=> !acc_req_o);

  a_r1_cmd_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && acc_we_o && acc_sel_o == SEL_CMD) |-> acc_wdata_o == CMD_READ);

  a_r2_head_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && acc_we_o && acc_sel_o == SEL_HEAD) |-> acc_wdata_o[7:4] == 4'hE);

  a_r8_err_starts_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (acc_req_o && acc_we_o && acc_sel_o == SEL_DEVCTL
                      && acc_wdata_o == SRST_SET));

  a_r8_err_clears_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> ($past(acc_done_i) && $past(acc_we_o)
                      && $past(acc_sel_o) == SEL_DEVCTL && $past(acc_wdata_o) == 8'h00));

  a_r5_done_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |-> ($past(host_load_i)
                     || ($past(acc_done_i) && !$past(acc_we_o) && $past(acc_sel_o) == SEL_DATA)));
endmodule

bind ata_sector_reader ata_sector_reader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_load_i(host_load_i),
  .host_done_o(host_done_o),
  .err_o      (err_o),
  .acc_req_o  (acc_req_o),
  .acc_we_o   (acc_we_o),
  .acc_sel_o  (acc_sel_o),
  .acc_wdata_o(acc_wdata_o),
  .acc_done_i (acc_done_i)
);

// File: tb/ata_sector_reader_test.sv
`timescale 1ns/1ps
module ata_sector_reader_test;
  localparam int RW = 40;
  localparam int LOGN = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_load_i = 1'b0;
  logic [27:0] host_lba_i = '0;
  logic        host_rd_i = 1'b0;
  logic        host_done_o;
  logic [15:0] host_word_o;
  logic        err_o;
  logic        acc_req_o, acc_we_o;
  logic [3:0]  acc_sel_o;
  logic [7:0]  acc_wdata_o;
  logic        acc_done_i;
  logic [15:0] acc_rdata_i;

  ata_sector_reader #(.WORDS_PER_SECTOR(256), .RST_WAIT(RW)) uut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0, overlap = 0, done_cnt = 0;
  int n = 0, t_rise = -1, t_fall = -1;
  logic err_prev = 1'b0;
  logic [3:0] lg_sel [LOGN];
  logic       lg_we  [LOGN];
  logic [7:0] lg_wd  [LOGN];
  int         lg_t   [LOGN];
  int words_left = 0, busy_polls = 0;
  logic srst = 0, err_mode = 0, inject_err = 0, force_valid = 0;
  logic [7:0] force_st = 0, card_lba0 = 0;
  int force_idx = -1;
  bit finished = 0;

  // {status, first action after it}: 0 poll, 1 drain, 2 issue, 3 soft reset
  localparam logic [9:0] VEC [11] = '{
    {8'h80, 2'd0}, {8'hD0, 2'd0}, {8'h00, 2'd0}, {8'hC0, 2'd0},
    {8'h58, 2'd1}, {8'h48, 2'd1}, {8'h50, 2'd2}, {8'h40, 2'd2},
    {8'h51, 2'd3}, {8'h01, 2'd3}, {8'h81, 2'd3}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial forever begin
    @(posedge clk_i);
    cyc++;
  end

  initial forever begin
    @(negedge clk_i);
    if (host_done_o) done_cnt++;
    if (err_o && !err_prev) t_rise = cyc;
    if (!err_o && err_prev) t_fall = cyc;
    err_prev = err_o;
  end

  // card model behind the register-access engine
  initial begin
    acc_done_i = 1'b0;
    acc_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      acc_done_i = 1'b0;
      if (acc_req_o) begin
        logic [3:0] s;
        logic w;
        logic [7:0] d;
        s = acc_sel_o; w = acc_we_o; d = acc_wdata_o;
        if (n < LOGN) begin
          lg_sel[n] = s; lg_we[n] = w; lg_wd[n] = d; lg_t[n] = cyc;
        end
        repeat (2) begin
          @(negedge clk_i);
          if (acc_req_o) overlap++;
        end
        acc_rdata_i = 16'h0000;
        if (w) begin
          if (s == 4'hB) card_lba0 = d;
          if (s == 4'hF && d == 8'h20) begin
            busy_polls = 2;
            words_left = 256;
            if (inject_err) begin
              err_mode = 1; inject_err = 0; words_left = 0;
            end
          end
          if (s == 4'h6) begin
            if (d == 8'h04) begin
              srst = 1; err_mode = 0; words_left = 0;
            end else begin
              srst = 0; busy_polls = 1;
            end
          end
        end else if (s == 4'hF) begin
          if (force_valid) begin
            acc_rdata_i = {8'h00, force_st}; force_valid = 0; force_idx = n;
          end else if (srst) acc_rdata_i = 16'h0080;
          else if (err_mode) acc_rdata_i = 16'h0051;
          else if (busy_polls > 0) begin
            busy_polls--; acc_rdata_i = 16'h0080;
          end else if (words_left > 0) acc_rdata_i = 16'h0058;
          else acc_rdata_i = 16'h0050;
        end else if (s == 4'h8) begin
          if (words_left > 0) begin
            acc_rdata_i = {card_lba0, 8'(256 - words_left)};
            words_left--;
          end else acc_rdata_i = 16'hDEAD;
        end
        n++;
        acc_done_i = 1'b1;
      end
    end
  end

  task automatic host_load(input logic [27:0] lba);
    @(negedge clk_i);
    host_load_i = 1'b1; host_lba_i = lba;
    @(negedge clk_i);
    host_load_i = 1'b0;
    chk(host_done_o == 1'b1, "R9 load done pulse", int'(host_done_o), 1);
  endtask

  task automatic host_read(output logic [15:0] w);
    int k;
    @(negedge clk_i);
    host_rd_i = 1'b1;
    @(negedge clk_i);
    host_rd_i = 1'b0;
    k = 0;
    while (!host_done_o && k < 20000) begin
      @(negedge clk_i);
      k++;
    end
    w = host_word_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    logic [15:0] w;
    int k, dr, d0, kk;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(acc_req_o == 0 && host_done_o == 0 && err_o == 0, "R11 reset outputs",
        {acc_req_o, host_done_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // status decode table: R3 R4 R8 R12
    for (int i = 0; i < 11; i++) begin
      logic [27:0] lba;
      int exp_act, act, sel_exp;
      lba = 28'(i * 37 + 5);
      host_load(lba);
      force_st = VEC[i][9:2];
      force_valid = 1;
      n = 0;
      host_read(w);
      exp_act = int'(VEC[i][1:0]);
      k = force_idx + 1;
      act = 4;
      if (k > 0 && k < LOGN) begin
        if (!lg_we[k] && lg_sel[k] == 4'hF) act = 0;
        else if (!lg_we[k] && lg_sel[k] == 4'h8) act = 1;
        else if (lg_we[k] && lg_sel[k] == 4'h9) act = 2;
        else if (lg_we[k] && lg_sel[k] == 4'h6 && lg_wd[k] == 8'h04) act = 3;
      end
      sel_exp = exp_act;
      chk(act == sel_exp, (exp_act == 3) ? "R8 decode error" :
          (exp_act == 0) ? "R12 decode busy" : (exp_act == 1) ? "R3 decode data" :
          "R4 decode command", act, sel_exp);
      chk(w == {lba[7:0], 8'h00}, "R5 first word after table entry", w, {lba[7:0], 8'h00});
    end

    // R1 R2 command sequence and R5 full sector
    host_load(28'h9A5C3E1);
    n = 0;
    host_read(w);
    k = -1;
    for (int j = 0; j < LOGN - 8 && j < n; j++)
      if (k < 0 && lg_we[j] && lg_sel[j] == 4'h9) k = j;
    chk(k >= 0, "R1 feature write present", k, 0);
    if (k >= 0) begin
      chk(lg_wd[k] == 8'h00, "R1 feature value", lg_wd[k], 0);
      chk(lg_sel[k+1] == 4'hA && lg_wd[k+1] == 8'h01, "R1 count write", {lg_sel[k+1], lg_wd[k+1]}, 12'hA01);
      chk(lg_sel[k+2] == 4'hB && lg_wd[k+2] == 8'hE1, "R1 lba0 write", {lg_sel[k+2], lg_wd[k+2]}, 12'hBE1);
      chk(lg_sel[k+3] == 4'hC && lg_wd[k+3] == 8'hC3, "R1 lba1 write", {lg_sel[k+3], lg_wd[k+3]}, 12'hCC3);
      chk(lg_sel[k+4] == 4'hD && lg_wd[k+4] == 8'hA5, "R1 lba2 write", {lg_sel[k+4], lg_wd[k+4]}, 12'hDA5);
      chk(lg_sel[k+5] == 4'hE && lg_wd[k+5] == 8'hE9, "R2 drive/head write", {lg_sel[k+5], lg_wd[k+5]}, 12'hEE9);
      chk(lg_we[k+6] && lg_sel[k+6] == 4'hF && lg_wd[k+6] == 8'h20, "R1 command write",
          {lg_sel[k+6], lg_wd[k+6]}, 12'hF20);
      chk(!lg_we[k+7] && lg_sel[k+7] == 4'hF, "R5 status poll after command", lg_sel[k+7], 4'hF);
    end
    chk(w == 16'hE100, "R5 word 0", w, 16'hE100);
    dr = 0;
    for (int i = 1; i < 256; i++) begin
      n = 0;
      host_read(w);
      if (n != 1 || lg_sel[0] != 4'h8 || lg_we[0] || w != {8'hE1, 8'(i)}) dr++;
    end
    chk(dr == 0, "R5 words 1..255 one data read each", dr, 0);

    // R6 sector boundary
    n = 0;
    host_read(w);
    kk = 0;
    for (int j = 0; j < n && j < LOGN; j++) if (lg_we[j] && lg_sel[j] == 4'hF) kk++;
    chk(!lg_we[0] && lg_sel[0] == 4'hF, "R6 status poll after last word", lg_sel[0], 4'hF);
    chk(kk == 1, "R6 new read command", kk, 1);
    chk(w == 16'hE100, "R6 first word of new sector", w, 16'hE100);

    // R7 drain and R9 new address
    host_read(w);
    host_read(w);
    host_load(28'h0000077);
    n = 0;
    d0 = done_cnt;
    host_read(w);
    dr = 0;
    k = -1;
    for (int j = 0; j < n && j < LOGN; j++) begin
      if (k < 0 && lg_we[j] && lg_sel[j] == 4'h9) k = j;
      if (k < 0 && !lg_we[j] && lg_sel[j] == 4'h8) dr++;
    end
    chk(dr == 253, "R7 dummy reads of leftover words", dr, 253);
    chk(done_cnt - d0 == 1, "R7 no host done during drain", done_cnt - d0, 1);
    chk(w == 16'h7700, "R9 word from new address", w, 16'h7700);

    // R8 error, timed soft reset, retry
    inject_err = 1;
    host_load(28'h0000042);
    n = 0;
    t_rise = -1; t_fall = -1;
    host_read(w);
    k = -1; kk = -1;
    for (int j = 0; j < n && j < LOGN; j++) begin
      if (k < 0 && lg_we[j] && lg_sel[j] == 4'h6 && lg_wd[j] == 8'h04) k = j;
      if (kk < 0 && lg_we[j] && lg_sel[j] == 4'h6 && lg_wd[j] == 8'h00) kk = j;
    end
    chk(t_rise >= 0, "R8 error output rose", t_rise, 0);
    chk(k >= 0 && kk > k, "R8 reset set then released", kk, k + 1);
    if (k >= 0 && kk > k)
      chk(lg_t[kk] - lg_t[k] >= RW && lg_t[kk] - lg_t[k] <= RW + 4, "R8 reset hold time",
          lg_t[kk] - lg_t[k], RW);
    if (kk >= 0)
      chk(t_fall > lg_t[kk] && t_rise <= lg_t[k] + 1, "R8 error window", t_fall, lg_t[kk] + 3);
    chk(err_o == 1'b0, "R8 error cleared after retry", err_o, 0);
    chk(w == 16'h4200, "R8 word after retry", w, 16'h4200);

    chk(overlap == 0, "R10 no request while outstanding", overlap, 0);
    summary();
  end
endmodule